// File: doc/BRIEF.md
# Hysteresis Bit Smoother for Scan Stimulus

This block sits in series between a pseudo-random bit source and the serial input of a scan chain. Its job is to lower the number of transitions in the stream shifted into the chain, and with it the switching power during self-test. It does this with hysteresis. The output only moves after the input has pushed an internal position across the middle of a line of `STATES` positions, so isolated opposite bits are absorbed.

The position S0..S(STATES-1) is held as a toggle register (the output, which selects the lower or upper half) and an up/down counter of modulus `STATES/2` (the place within that half). Each enabled cycle moves the position one place: up for a 1, down for a 0. A carry out of the lower half or a borrow out of the upper half flips the toggle register. At the two outer ends the position saturates. `STATES` is a parameter; 4 gives the two-bit variant and 8 the three-bit variant.

Top module: `bit_smoother`

## Requirements
- R1: A synchronous active-high reset puts the block in S0: output 0 and counter 0, visible after the reset edge.
- R2: The position index is output*(STATES/2) + counter. Each enabled cycle moves it one place up for an input 1 and one place down for an input 0. The output is 1 exactly when the position lies in the upper half, S(STATES/2)..S(STATES-1).
- R3: The output is registered. It changes only at the clock edge that samples an enabled input bit equal to the new output value, and the change is visible after that edge.
- R4: An input 1 in S(STATES/2-1) moves to S(STATES/2) and raises the output. An input 0 in S(STATES/2) moves to S(STATES/2-1) and lowers it. From S0, STATES/2 consecutive 1s raise the output on the last of them.
- R5: While enable is low, the input bit is ignored and both the position and the output hold.
- R6: The ends saturate. A 1 in S(STATES-1) stays there with output 1, and a 0 in S0 stays there with output 0.
- R7: Starting from S0, an alternating 1/0 stream (beginning with either bit) never changes the output.
- R8: For an evenly random input stream, the long-run fraction of cycles in which the output toggles is about 1/STATES: within 0.05 of it over 4000 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Advance enable; low freezes the block |
| din | input | 1 | Serial bit from the random source |
| dout | output | 1 | Smoothed serial bit toward the scan input |

## Verification
The bench drives the 4-state and 8-state variants side by side with the same bit stream, so a run of a given length flips one variant and not the other. This separates the half-width count from an off-by-one. Long runs of ones and zeros expose whether the ends saturate or wrap, and an alternating stream shows that isolated bits are absorbed. Bits offered while enable is low are followed by a single enabled 1 that flips the 4-state output only if the position was really held. A long LFSR-driven stream checks every cycle against a position model and then compares the toggle fraction with 1/STATES.

// File: rtl/smoother_pkg.sv
package smoother_pkg;
  // Direction of one position move for the hysteresis line
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;

  function automatic step_e decode_step(input logic enable, input logic bit_in);
    if (!enable)     return STEP_HOLD;
    else if (bit_in) return STEP_UP;
    else             return STEP_DOWN;
  endfunction
endpackage

// File: rtl/smooth_half_counter.sv
module smooth_half_counter
  import smoother_pkg::*;
#(
  parameter int HALF = 2,
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  step_e         step,
  input  logic          hold_top,
  input  logic          hold_bot,
  output logic [CW-1:0] cnt,
  output logic          carry,
  output logic          borrow
);
  localparam logic [CW-1:0] CNT_TOP = CW'(HALF - 1);

  logic at_top;
  logic at_bot;

  generate
    if ((HALF & (HALF - 1)) == 0) begin : g_pow2
      assign at_top = &cnt;
    end else begin : g_any
      assign at_top = (cnt == CNT_TOP);
    end
  endgenerate

  assign at_bot = (cnt == '0);
  assign carry  = (step == STEP_UP)   && at_top && !hold_top;
  assign borrow = (step == STEP_DOWN) && at_bot && !hold_bot;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else begin
      unique case (step)
        STEP_UP: begin
          if (carry)       cnt <= '0;
          else if (!at_top) cnt <= cnt + 1'b1;
        end
        STEP_DOWN: begin
          if (borrow)      cnt <= CNT_TOP;
          else if (!at_bot) cnt <= cnt - 1'b1;
        end
        default: cnt <= cnt;
      endcase
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_TOP); // R2
  AST_CARRY_WRAP: assert property (@(posedge clk) disable iff (rst)
    carry |=> (cnt == '0)); // R4
  AST_BORROW_WRAP: assert property (@(posedge clk) disable iff (rst)
    borrow |=> (cnt == CNT_TOP)); // R4
  AST_UP_ONE_PLACE: assert property (@(posedge clk) disable iff (rst)
    (step == STEP_UP && !at_top) |=> (cnt == $past(cnt) + 1'b1)); // R2
endmodule

// File: rtl/smooth_toggle_reg.sv
module smooth_toggle_reg (
  input  logic clk,
  input  logic rst,
  input  logic t,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= q ^ t;
  end

  AST_FLIP_ONLY_ON_T: assert property (@(posedge clk) disable iff (rst)
    !t |=> $stable(q)); // R3
endmodule

// File: rtl/bit_smoother.sv
module bit_smoother
  import smoother_pkg::*;
#(
  parameter int STATES = 4,
  localparam int HALF = STATES / 2,
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic din,
  output logic dout
);
  localparam logic [CW-1:0] CNT_TOP = CW'(HALF - 1);

  step_e         step;
  logic [CW-1:0] cnt;
  logic          carry;
  logic          borrow;
  logic          half_q;

  assign step = decode_step(en, din);

  // In the upper half the counter top is the absolute top end; in the
  // lower half the counter bottom is the absolute bottom end.
  smooth_half_counter #(.HALF(HALF)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .step     (step),
    .hold_top (half_q),
    .hold_bot (~half_q),
    .cnt      (cnt),
    .carry    (carry),
    .borrow   (borrow)
  );

  smooth_toggle_reg u_half (
    .clk (clk),
    .rst (rst),
    .t   (carry | borrow),
    .q   (half_q)
  );

  assign dout = half_q;

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (dout == 1'b0 && cnt == '0)); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(dout) && $stable(cnt))); // R5
  AST_FLIP_FOLLOWS_INPUT: assert property (@(posedge clk) disable iff (rst)
    en |=> (dout == $past(dout) || dout == $past(din))); // R3
  AST_MID_CROSS_UP: assert property (@(posedge clk) disable iff (rst)
    (en && din && !dout && cnt == CNT_TOP) |=> (dout && cnt == '0)); // R4
  AST_MID_CROSS_DOWN: assert property (@(posedge clk) disable iff (rst)
    (en && !din && dout && cnt == '0) |=> (!dout && cnt == CNT_TOP)); // R4
  AST_TOP_SATURATE: assert property (@(posedge clk) disable iff (rst)
    (en && din && dout && cnt == CNT_TOP) |=> (dout && cnt == CNT_TOP)); // R6
  AST_BOT_SATURATE: assert property (@(posedge clk) disable iff (rst)
    (en && !din && !dout && cnt == '0) |=> (!dout && cnt == '0)); // R6
endmodule

// File: tb/bit_smoother_bench.sv
`timescale 1ns/1ps
module bit_smoother_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic din = 1'b0;
  logic dout4;
  logic dout8;

  always #4 clk = ~clk;

  bit_smoother #(.STATES(4)) u_bit_smoother (
    .clk(clk), .rst(rst), .en(en), .din(din), .dout(dout4));
  bit_smoother #(.STATES(8)) u_bit_smoother_w8 (
    .clk(clk), .rst(rst), .en(en), .din(din), .dout(dout8));

  typedef struct {
    logic  e4;
    logic  e8;
    string tag;
  } exp_t;

  exp_t sb[$];
  int   n_checks = 0;
  int   n_fail   = 0;
  int   pos4 = 0;
  int   pos8 = 0;
  bit   measuring = 1'b0;
  int   tog4 = 0;
  int   tog8 = 0;
  logic prev4 = 1'b0;
  logic prev8 = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  localparam int RAND_BITS = 4000;

  function automatic int move(input int p, input int n, input bit b);
    if (b) return (p < n - 1) ? p + 1 : p;
    else   return (p > 0) ? p - 1 : p;
  endfunction

  task automatic check_bit(input string tag, input string which,
                           input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0b expected %0b at %0t", tag, which, act, exp, $time);
    end
  endtask

  task automatic apply(input logic b, input logic e, input string tag);
    @(negedge clk);
    din = b;
    en  = e;
    if (e) begin
      pos4 = move(pos4, 4, b);
      pos8 = move(pos8, 8, b);
    end
    sb.push_back('{(pos4 >= 2), (pos8 >= 4), tag});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    en  = 1'b0;
    pos4 = 0;
    pos8 = 0;
    sb.push_back('{1'b0, 1'b0, "R1"});
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic drain();
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic check_rate(input string which, input int toggles, input int states);
    real rate;
    real want;
    rate = real'(toggles) / real'(RAND_BITS);
    want = 1.0 / real'(states);
    n_checks++;
    if (rate < want - 0.05 || rate > want + 0.05) begin
      n_fail++;
      $display("FAIL R8 %s: toggle rate %f expected %f +/- 0.05", which, rate, want);
    end
  endtask

  // Monitor: compares after every edge that has a queued expectation
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check_bit(e.tag, "w4", dout4, e.e4);
        check_bit(e.tag, "w8", dout8, e.e8);
        if (measuring) begin
          if (dout4 !== prev4) tog4++;
          if (dout8 !== prev8) tog8++;
          prev4 = dout4;
          prev8 = dout8;
        end
      end
    end
  end

  // Watchdog
  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    do_reset();                                       // R1
    for (int i = 0; i < 4; i++) apply(1'b1, 1'b1, "R4"); // w4 rises on 2nd, w8 on 4th
    for (int i = 0; i < 8; i++) apply(1'b1, 1'b1, "R6"); // both pinned at top
    for (int i = 0; i < 8; i++) apply(1'b0, 1'b1, "R4"); // fall after half+... places
    for (int i = 0; i < 5; i++) apply(1'b0, 1'b1, "R6"); // pinned at bottom
    for (int i = 0; i < 2; i++) apply(1'b1, 1'b1, "R6"); // w4 rises: bottom did not wrap

    do_reset();                                       // R1 from upper half
    for (int i = 0; i < 20; i++) apply(i[0] ? 1'b0 : 1'b1, 1'b1, "R7");
    do_reset();
    for (int i = 0; i < 20; i++) apply(i[0] ? 1'b1 : 1'b0, 1'b1, "R7");

    do_reset();
    apply(1'b1, 1'b1, "R2");                          // both at S1
    for (int i = 0; i < 5; i++) apply(1'b1, 1'b0, "R5");
    apply(1'b1, 1'b1, "R5");                          // w4 rises only if S1 was held
    for (int i = 0; i < 5; i++) apply(1'b0, 1'b0, "R5");
    apply(1'b0, 1'b1, "R5");                          // w4 falls from S2

    do_reset();
    drain();
    prev4 = dout4;
    prev8 = dout8;
    measuring = 1'b1;
    for (int i = 0; i < RAND_BITS; i++) begin
      logic b;
      b = lfsr[0];
      lfsr = {1'b0, lfsr[15:1]} ^ (lfsr[0] ? 16'hB400 : 16'h0000);
      apply(b, 1'b1, "R3");
    end
    drain();
    measuring = 1'b0;
    check_rate("w4", tog4, 4);
    check_rate("w8", tog8, 8);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule